// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

The sequencer takes one high-level flash request and turns it into the fixed series of bus cycles that a standard parallel NOR flash expects. A request can be an ID read, a single-word program, a block erase, a whole-device erase, a return to array-read mode, a common flash interface query, or a plain data read. Each request is handed over on a valid/ready handshake. The block then plays its write script on a simple memory-bus master port, followed by any read cycles the request needs. Each captured read word is returned with its index, and a one-cycle `done` pulse marks the end of the request.

Command offsets are word offsets added to a base address supplied with the request. In 16-bit device mode the offset is doubled to form a byte address. In 8-bit mode it is used as is. Target addresses for program, block erase and data read are absolute bus addresses and are never scaled. A write-protect input makes program and erase requests finish at once, flagged with an error and with no bus traffic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, `busy`, `done`, `err`, `rsp_valid`, `bus_we` and `bus_re` are 0.
- R2: Every ID read, program, block erase, device erase and data read begins with two unlock writes: 0xAA to offset 0x555, then 0x55 to offset 0x2AA.
- R3: Op code 0 (ID read) follows the unlock with a write of 0x90 to offset 0x555. It then reads offsets 0x00, 0x01, 0x0E and 0x0F in that order and returns the four words with `rsp_idx` 0 to 3.
- R4: Op code 1 (program) follows the unlock with 0xA0 to offset 0x555, then writes `req_wdata` to `req_addr`.
- R5: Op codes 2 (block erase) and 3 (device erase) follow the unlock with 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA. Block erase ends with 0x30 written to `req_addr`; device erase ends with 0x10 written to offset 0x555.
- R6: Op code 4 (return to read mode) is one write of 0xF0 to `base_addr`.
- R7: Op code 5 (query) is one write of 0x98 to offset 0x55, followed by reads of offsets 0x10, 0x11, 0x12 and 0x13, returned with `rsp_idx` 0 to 3.
- R8: Op code 6 (data read) follows the unlock with 0xF0 written to `req_addr`, then reads `req_addr` once and returns that word with `rsp_idx` 0.
- R9: A command offset appears on `bus_addr` as `base_addr + offset` when `mode16` is 0 and as `base_addr + 2*offset` when `mode16` is 1.
- R10: Each bus cycle holds exactly one of `bus_we`/`bus_re` high for `STROBE_CLKS` clocks, and at least one clock with both low follows every cycle.
- R11: While a request is in progress `req_ready` is 0, `busy` is 1, and a `req_valid` presented then is ignored and causes no bus cycle.
- R12: With `wp` high at acceptance, op codes 1, 2 and 3 give `done` with `err` high on the next clock and no bus cycle. Op codes 0, 4, 5 and 6 run normally with `err` low.
- R13: `done` is a one-clock pulse at the end of each request. Op code 7 is reserved and completes like a write-protected request, with `err` high and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_op | input | 3 | Operation code (see R3 to R8, R13) |
| req_addr | input | AW | Absolute target address for program, block erase and data read |
| req_wdata | input | DW | Word to program |
| base_addr | input | AW | Device base address for command offsets |
| mode16 | input | 1 | 1 = 16-bit device (offsets doubled), 0 = 8-bit |
| wp | input | 1 | Write protect, blocks program and erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock end-of-request pulse |
| err | output | 1 | Request rejected, valid with `done` |
| rsp_valid | output | 1 | Captured read word valid |
| rsp_idx | output | 2 | Index of the read word within the request |
| rsp_data | output | DW | Captured read word |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DW | Bus read data, sampled on the last strobe clock |

## Verification
The bench builds the block with a 20-bit address, a 16-bit data word and `STROBE_CLKS` = 3. This makes the strobe counter pass through an intermediate value rather than end on its first count. Base addresses chosen well above the command offsets make an unscaled or doubled offset visible as a distinct bus address. Both device modes are covered by driving `mode16` per request. A bus model that returns an address-derived word lets every read step be tied to the exact address it targeted.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ_ID   = 3'd0,
    OP_PROGRAM   = 3'd1,
    OP_ERASE_BLK = 3'd2,
    OP_ERASE_ALL = 3'd3,
    OP_READ_MODE = 3'd4,
    OP_QUERY     = 3'd5,
    OP_READ      = 3'd6,
    OP_RSVD      = 3'd7
  } nor_op_e;

  typedef enum logic [1:0] {
    CY_END = 2'd0,
    CY_WR  = 2'd1,
    CY_RD  = 2'd2
  } cyc_kind_e;

  // word offsets of the command cycles
  localparam logic [11:0] OFF_KEY_A = 12'h555;
  localparam logic [11:0] OFF_KEY_B = 12'h2AA;
  localparam logic [11:0] OFF_QUERY = 12'h055;

  // command codes
  localparam logic [7:0] CODE_KEY_A   = 8'hAA;
  localparam logic [7:0] CODE_KEY_B   = 8'h55;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERASE   = 8'h80;
  localparam logic [7:0] CODE_SECTOR  = 8'h30;
  localparam logic [7:0] CODE_WHOLE   = 8'h10;
  localparam logic [7:0] CODE_ARRAY   = 8'hF0;
  localparam logic [7:0] CODE_QUERY   = 8'h98;

  function automatic logic op_alters_array(input nor_op_e op);
    return (op == OP_PROGRAM) || (op == OP_ERASE_BLK) || (op == OP_ERASE_ALL);
  endfunction

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  nor_op_e         op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   tgt,
  input  logic [DW-1:0]   wdata,
  input  logic            mode16,
  output cyc_kind_e       kind,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   data
);

  // offset scaling: doubled for 16-bit devices
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b,
                                               input logic [11:0]   off,
                                               input logic          m16);
    logic [AW-1:0] o;
    o = AW'(off);
    if (m16) o = o << 1;
    return b + o;
  endfunction

  function automatic logic [DW-1:0] code(input logic [7:0] c);
    return DW'(c);
  endfunction

  logic [11:0] off;
  logic        use_tgt;

  always_comb begin
    kind    = CY_END;
    off     = 12'h000;
    use_tgt = 1'b0;
    data    = '0;
    case (op)
      OP_READ_ID, OP_PROGRAM, OP_ERASE_BLK, OP_ERASE_ALL, OP_READ: begin
        if (step == 3'd0) begin
          kind = CY_WR; off = OFF_KEY_A; data = code(CODE_KEY_A);
        end else if (step == 3'd1) begin
          kind = CY_WR; off = OFF_KEY_B; data = code(CODE_KEY_B);
        end else begin
          case (op)
            OP_READ_ID: begin
              case (step)
                3'd2: begin kind = CY_WR; off = OFF_KEY_A; data = code(CODE_IDENT); end
                3'd3: begin kind = CY_RD; off = 12'h000; end
                3'd4: begin kind = CY_RD; off = 12'h001; end
                3'd5: begin kind = CY_RD; off = 12'h00E; end
                3'd6: begin kind = CY_RD; off = 12'h00F; end
                default: kind = CY_END;
              endcase
            end
            OP_PROGRAM: begin
              case (step)
                3'd2: begin kind = CY_WR; off = OFF_KEY_A; data = code(CODE_PROG); end
                3'd3: begin kind = CY_WR; use_tgt = 1'b1; data = wdata; end
                default: kind = CY_END;
              endcase
            end
            OP_ERASE_BLK, OP_ERASE_ALL: begin
              case (step)
                3'd2: begin kind = CY_WR; off = OFF_KEY_A; data = code(CODE_ERASE); end
                3'd3: begin kind = CY_WR; off = OFF_KEY_A; data = code(CODE_KEY_A); end
                3'd4: begin kind = CY_WR; off = OFF_KEY_B; data = code(CODE_KEY_B); end
                3'd5: begin
                  kind = CY_WR;
                  if (op == OP_ERASE_BLK) begin
                    use_tgt = 1'b1; data = code(CODE_SECTOR);
                  end else begin
                    off = OFF_KEY_A; data = code(CODE_WHOLE);
                  end
                end
                default: kind = CY_END;
              endcase
            end
            default: begin
              case (step)
                3'd2: begin kind = CY_WR; use_tgt = 1'b1; data = code(CODE_ARRAY); end
                3'd3: begin kind = CY_RD; use_tgt = 1'b1; end
                default: kind = CY_END;
              endcase
            end
          endcase
        end
      end
      OP_READ_MODE: begin
        if (step == 3'd0) begin
          kind = CY_WR; off = 12'h000; data = code(CODE_ARRAY);
        end
      end
      OP_QUERY: begin
        if (step == 3'd0) begin
          kind = CY_WR; off = OFF_QUERY; data = code(CODE_QUERY);
        end else if (step <= 3'd4) begin
          kind = CY_RD; off = 12'h00F + 12'(step);
        end
      end
      default: kind = CY_END;
    endcase
  end

  assign addr = use_tgt ? tgt : word_addr(base, off, mode16);

endmodule

// File: rtl/nor_seq_bus.sv
module nor_seq_bus
  import nor_seq_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cyc_kind_e       kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [DW-1:0]   bus_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic            bus_re,
  output logic            fin,
  output logic [DW-1:0]   rd_word
);

  localparam int CW = (STROBE_CLKS < 2) ? 1 : $clog2(STROBE_CLKS);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  typedef enum logic [1:0] {E_IDLE, E_ACT, E_GAP} eng_st_e;

  eng_st_e        st;
  logic [CW-1:0]  cnt;
  logic           is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cnt       <= '0;
      is_rd     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_word   <= '0;
    end else begin
      case (st)
        E_IDLE: begin
          if (start) begin
            bus_addr  <= addr_i;
            bus_wdata <= data_i;
            is_rd     <= (kind_i == CY_RD);
            cnt       <= '0;
            st        <= E_ACT;
          end
        end
        E_ACT: begin
          if (cnt == LAST) begin
            if (is_rd) rd_word <= bus_rdata;
            st <= E_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign bus_we = (st == E_ACT) && !is_rd;
  assign bus_re = (st == E_ACT) &&  is_rd;
  assign fin    = (st == E_GAP);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [AW-1:0]   base_addr,
  input  logic            mode16,
  input  logic            wp,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            rsp_valid,
  output logic [1:0]      rsp_idx,
  output logic [DW-1:0]   rsp_data,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_we,
  output logic            bus_re,
  input  logic [DW-1:0]   bus_rdata
);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT, T_DONE} top_st_e;

  top_st_e        st;
  nor_op_e        op_q;
  logic [AW-1:0]  tgt_q, base_q;
  logic [DW-1:0]  wd_q;
  logic           m16_q;
  logic [2:0]     step_q;
  logic [1:0]     rdi_q;
  logic           err_q;

  cyc_kind_e      sc_kind;
  logic [AW-1:0]  sc_addr;
  logic [DW-1:0]  sc_data;
  logic           eng_start, eng_fin;
  logic [DW-1:0]  eng_rd;

  // named events for the checker
  logic    accept, reject;
  nor_op_e in_op;

  assign in_op  = nor_op_e'(req_op);
  assign accept = (st == T_IDLE) && req_valid;
  assign reject = (op_alters_array(in_op) && wp) || (in_op == OP_RSVD);

  nor_seq_script #(.AW(AW), .DW(DW)) u_script (
    .op(op_q), .step(step_q), .base(base_q), .tgt(tgt_q), .wdata(wd_q),
    .mode16(m16_q), .kind(sc_kind), .addr(sc_addr), .data(sc_data)
  );

  assign eng_start = (st == T_ISSUE) && (sc_kind != CY_END);

  nor_seq_bus #(.AW(AW), .DW(DW), .STROBE_CLKS(STROBE_CLKS)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .kind_i(sc_kind),
    .addr_i(sc_addr), .data_i(sc_data), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .fin(eng_fin), .rd_word(eng_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_IDLE;
      op_q   <= OP_READ_MODE;
      tgt_q  <= '0;
      base_q <= '0;
      wd_q   <= '0;
      m16_q  <= 1'b0;
      step_q <= '0;
      rdi_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        T_IDLE: begin
          if (accept) begin
            op_q   <= in_op;
            tgt_q  <= req_addr;
            base_q <= base_addr;
            wd_q   <= req_wdata;
            m16_q  <= mode16;
            step_q <= '0;
            rdi_q  <= '0;
            err_q  <= reject;
            st     <= reject ? T_DONE : T_ISSUE;
          end
        end
        T_ISSUE: st <= (sc_kind == CY_END) ? T_DONE : T_WAIT;
        T_WAIT: begin
          if (eng_fin) begin
            step_q <= step_q + 3'd1;
            if (sc_kind == CY_RD) rdi_q <= rdi_q + 2'd1;
            st <= T_ISSUE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign req_ready = (st == T_IDLE);
  assign busy      = !req_ready;
  assign done      = (st == T_DONE);
  assign err       = done && err_q;
  assign rsp_valid = (st == T_WAIT) && eng_fin && (sc_kind == CY_RD);
  assign rsp_idx   = rdi_q;
  assign rsp_data  = eng_rd;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int STROBE_CLKS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       wp,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       rsp_valid,
  input logic       bus_we,
  input logic       bus_re
);

  logic strobe;
  int   hi_cnt;
  assign strobe = bus_we || bus_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 0;
    else        hi_cnt <= strobe ? hi_cnt + 1 : 0;
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (hi_cnt == STROBE_CLKS));

  p_strobe_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |=> !strobe);

  p_take_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && busy));

  p_protect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && wp && (req_op inside {3'd1, 3'd2, 3'd3}))
      |=> (done && err));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strobe);

  p_rsp_in_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (busy && !done));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.STROBE_CLKS(STROBE_CLKS)) u_chk (.*);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;

  localparam int CLK_NS = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int SC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] base_addr = '0;
  logic          mode16 = 1'b0;
  logic          wp = 1'b0;
  logic          busy, done, err, rsp_valid;
  logic [1:0]    rsp_idx;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we, bus_re;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign bus_rdata = bus_re ? mem_val(bus_addr) : 16'hDEAD;

  nor_cmd_seq #(.AW(AW), .DW(DW), .STROBE_CLKS(SC)) uut (.*);

  typedef struct {
    logic          rd;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } bus_exp_t;

  typedef struct {
    logic [DW-1:0] d;
    logic [1:0]    idx;
    string         tag;
  } rsp_exp_t;

  bus_exp_t bq[$];
  rsp_exp_t rq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] cmd_at(input logic [AW-1:0] b,
                                            input int off, input logic m16);
    return b + AW'(m16 ? off * 2 : off);
  endfunction

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input string tag);
    bus_exp_t e;
    e.rd = 1'b0; e.a = a; e.d = d; e.tag = tag;
    bq.push_back(e);
  endtask

  task automatic push_rd(input logic [AW-1:0] a, input logic [1:0] idx,
                         input string tag);
    bus_exp_t e;
    rsp_exp_t r;
    e.rd = 1'b1; e.a = a; e.d = '0; e.tag = tag;
    bq.push_back(e);
    r.d = mem_val(a); r.idx = idx; r.tag = tag;
    rq.push_back(r);
  endtask

  task automatic push_unlock(input logic [AW-1:0] b, input logic m16);
    push_wr(cmd_at(b, 'h555, m16), 16'h00AA, "R2");
    push_wr(cmd_at(b, 'h2AA, m16), 16'h0055, "R2");
  endtask

  // monitor: compares bus cycles and read words as they appear
  logic prev_strobe = 1'b0;
  int   hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_we && bus_re) chk(0, "R10", "both strobes", 1, 0);
      if ((bus_we || bus_re) && !prev_strobe) begin
        if (bq.size() == 0) begin
          chk(0, "R11", "unexpected bus cycle addr", 32'(bus_addr), 0);
        end else begin
          bus_exp_t e;
          e = bq.pop_front();
          chk(bus_re == e.rd, e.tag, "cycle kind", 32'(bus_re), 32'(e.rd));
          chk(bus_addr == e.a, e.tag, "bus addr", 32'(bus_addr), 32'(e.a));
          if (!e.rd)
            chk(bus_wdata == e.d, e.tag, "bus data", 32'(bus_wdata), 32'(e.d));
        end
      end
      if (bus_we || bus_re) hi++;
      else if (prev_strobe) begin
        chk(hi == SC, "R10", "strobe width", 32'(hi), 32'(SC));
        hi = 0;
      end
      prev_strobe = bus_we || bus_re;
      if (rsp_valid) begin
        if (rq.size() == 0) begin
          chk(0, "R3", "unexpected read word", 32'(rsp_data), 0);
        end else begin
          rsp_exp_t r;
          r = rq.pop_front();
          chk(rsp_data == r.d, r.tag, "read word", 32'(rsp_data), 32'(r.d));
          chk(rsp_idx == r.idx, r.tag, "read index", 32'(rsp_idx), 32'(r.idx));
        end
      end
    end
  end

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [AW-1:0] b,
                       input logic m16, input logic prot,
                       input logic exp_err, input string tag);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    base_addr = b; mode16 = m16; wp = prot;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk(done == 1'b1, tag, "done seen", 32'(done), 1);
    chk(err == exp_err, tag, "err flag", 32'(err), 32'(exp_err));
    if (exp_err) chk(n == 0, "R12", "reject latency", 32'(n), 0);
    chk(bq.size() == 0, tag, "cycles left", 32'(bq.size()), 0);
    chk(rq.size() == 0, tag, "words left", 32'(rq.size()), 0);
    @(negedge clk);
    chk(done == 1'b0, "R13", "done pulse width", 32'(done), 0);
    wp = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] b16, b8;
    b16 = 20'h80000;
    b8  = 20'h40000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", 32'({done, err}), 0);
    chk(!bus_we && !bus_re && !rsp_valid, "R1", "strobes after reset",
        32'({bus_we, bus_re, rsp_valid}), 0);
    rst_n = 1'b1;

    // R3 R9 ID read, 16-bit mode
    push_unlock(b16, 1'b1);
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h0090, "R3");
    push_rd(cmd_at(b16, 'h00, 1'b1), 2'd0, "R3");
    push_rd(cmd_at(b16, 'h01, 1'b1), 2'd1, "R3");
    push_rd(cmd_at(b16, 'h0E, 1'b1), 2'd2, "R3");
    push_rd(cmd_at(b16, 'h0F, 1'b1), 2'd3, "R3");
    do_op(3'd0, '0, '0, b16, 1'b1, 1'b0, 1'b0, "R3");

    // R4 program
    push_unlock(b16, 1'b1);
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h00A0, "R4");
    push_wr(20'h81234, 16'hBEEF, "R4");
    do_op(3'd1, 20'h81234, 16'hBEEF, b16, 1'b1, 1'b0, 1'b0, "R4");

    // R5 block erase
    push_unlock(b16, 1'b1);
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h0080, "R5");
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h00AA, "R5");
    push_wr(cmd_at(b16, 'h2AA, 1'b1), 16'h0055, "R5");
    push_wr(20'h84000, 16'h0030, "R5");
    do_op(3'd2, 20'h84000, '0, b16, 1'b1, 1'b0, 1'b0, "R5");

    // R5 device erase
    push_unlock(b16, 1'b1);
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h0080, "R5");
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h00AA, "R5");
    push_wr(cmd_at(b16, 'h2AA, 1'b1), 16'h0055, "R5");
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h0010, "R5");
    do_op(3'd3, 20'h84000, '0, b16, 1'b1, 1'b0, 1'b0, "R5");

    // R6 return to read mode
    push_wr(b16, 16'h00F0, "R6");
    do_op(3'd4, 20'h81234, '0, b16, 1'b1, 1'b0, 1'b0, "R6");

    // R7 R9 query, 8-bit mode
    push_wr(cmd_at(b8, 'h55, 1'b0), 16'h0098, "R7");
    for (int i = 0; i < 4; i++)
      push_rd(cmd_at(b8, 'h10 + i, 1'b0), 2'(i), "R7");
    do_op(3'd5, '0, '0, b8, 1'b0, 1'b0, 1'b0, "R7");

    // R8 plain data read, 8-bit mode
    push_unlock(b8, 1'b0);
    push_wr(20'h40321, 16'h00F0, "R8");
    push_rd(20'h40321, 2'd0, "R8");
    do_op(3'd6, 20'h40321, '0, b8, 1'b0, 1'b0, 1'b0, "R8");

    // R9 program with unscaled offsets
    push_unlock(b8, 1'b0);
    push_wr(cmd_at(b8, 'h555, 1'b0), 16'h00A0, "R9");
    push_wr(20'h40010, 16'h1357, "R9");
    do_op(3'd1, 20'h40010, 16'h1357, b8, 1'b0, 1'b0, 1'b0, "R9");

    // R12 write protect blocks alteration, reads still run
    do_op(3'd1, 20'h40010, 16'h1111, b8, 1'b0, 1'b1, 1'b1, "R12");
    do_op(3'd2, 20'h44000, '0, b8, 1'b0, 1'b1, 1'b1, "R12");
    do_op(3'd3, '0, '0, b16, 1'b1, 1'b1, 1'b1, "R12");
    push_wr(cmd_at(b16, 'h55, 1'b1), 16'h0098, "R12");
    for (int i = 0; i < 4; i++)
      push_rd(cmd_at(b16, 'h10 + i, 1'b1), 2'(i), "R12");
    do_op(3'd5, '0, '0, b16, 1'b1, 1'b1, 1'b0, "R12");

    // R13 reserved code
    do_op(3'd7, '0, '0, b16, 1'b1, 1'b0, 1'b1, "R13");

    // R11 request during an operation is ignored
    push_unlock(b16, 1'b1);
    push_wr(cmd_at(b16, 'h555, 1'b1), 16'h00A0, "R11");
    push_wr(20'h8ABCE, 16'h2468, "R11");
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 20'h8ABCE; req_wdata = 16'h2468;
    base_addr = b16; mode16 = 1'b1; wp = 1'b0;
    @(negedge clk);
    req_op = 3'd3;
    for (int i = 0; i < 4; i++) begin
      chk(req_ready == 1'b0, "R11", "ready while busy", 32'(req_ready), 0);
      chk(busy == 1'b1, "R11", "busy flag", 32'(busy), 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    begin
      int n;
      n = 0;
      while (!done && n < 400) begin @(negedge clk); n++; end
    end
    chk(done == 1'b1 && err == 1'b0, "R11", "first op completes", 32'({done, err}), 2);
    repeat (40) @(negedge clk);
    chk(bq.size() == 0, "R11", "cycles left", 32'(bq.size()), 0);
    chk(req_ready == 1'b1, "R11", "idle afterwards", 32'(req_ready), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule